// File: doc/BRIEF.md
# Cascadable Four-Channel Pulse-Width Modulator

This block holds four 8-bit pulse-width channels, each with its own output pin. Adjacent channels can be fused two by two, so the block can also run as two 16-bit channels. Every counter advances on a shared tick. Software chooses where that tick comes from: a free-running time-base strobe or the one-cycle overflow strobe of an external 8-bit reload timer.

Software programs the block through a small write-only register port. Period and duty values first land in shadow registers. A channel takes them over only at the end of a period, or at any time while it is switched off, so a waveform is never cut mid-period.

A fused pair can also run in a dithered mode meant for digital-to-analog use. In this mode a 65536-tick frame is split into 256 subperiods. The upper duty byte sets the base high time of each subperiod. The lower byte picks how many subperiods get one extra tick, and those subperiods are spread evenly through the frame.

Top module: `pwm_cascade`

## Requirements
- R1: While reset is asserted and after it is released, all four outputs are low. All shadow and active registers and all control bits reset to zero, so enabling channel 0 with no register written keeps its output low.
- R2: In 8-bit operation a channel counter counts selected ticks from 0 up to period-1 and then wraps to 0. The output is high exactly while counter < duty. A period of 0 or 1 gives a one-tick cycle.
- R3: A duty of 0 keeps the output low. A duty greater than or equal to the period keeps it high.
- R4: A disabled channel drives its output low and holds its counter at zero. After it is enabled, the k-th selected tick position of the first period is high exactly when k < duty.
- R5: Mode bit 4 picks the tick source: 0 selects `tb_tick` and 1 selects `tmr_ovf`. The source that is not selected has no effect. Without a selected tick the counters hold their value.
- R6: Period and duty writes go to shadow registers. A running channel copies them into its active registers only at a wrap. A disabled channel copies them every cycle. A shadow write that lands on the same clock edge as a wrap is not used by that wrap; it takes effect at the following wrap.
- R7: Register map on `wr_addr`: 0 to 3 are the channel 0 to 3 periods and 4 to 7 are the channel 0 to 3 duties. Address 8 bits 3:0 are the channel enables. Address 9 is the mode: bit 0 fuses pair A, bit 1 fuses pair B, bit 2 turns on dithering for pair A, bit 3 turns on dithering for pair B, and bit 4 selects the tick source. All other addresses are ignored.
- R8: A fused pair uses its even channel as the low byte and its odd channel as the high byte of a 16-bit period, duty and counter. The low byte's carry advances the high byte. The 16-bit waveform appears on the even pin, the odd pin stays low, and only the even channel's enable bit controls the pair.
- R9: In dithered mode the period registers are ignored and the frame is 65536 ticks long. Subperiod s (ticks 256s to 256s+255) is high for dutyHigh ticks, plus one extra tick when the 8-bit bit-reversal of s is less than dutyLow. The frame total is therefore the full 16-bit duty.
- R10: Channels that are not fused run independently, each with its own period and duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tb_tick | input | 1 | Time-base tick strobe |
| tmr_ovf | input | 1 | One-cycle overflow strobe from the reload timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 4 | Pulse-width outputs, bit n for channel n |

## Verification
Two events can fall on the same clock edge: a shadow register write and a counter wrap that copies the shadows into the active registers. The bench creates this case by starting a channel from a known counter phase, then placing a duty write in the exact cycle where the counter sits at period-1. It then counts high cycles over the next two periods: the first must still show the earlier duty and the second the newly written one. A second bench scenario checks that a write placed in the middle of a period leaves the current period unchanged.

// File: rtl/pwm_cascade_pkg.sv
package pwm_cascade_pkg;

  localparam int NUM_CH   = 4;
  localparam int NUM_PAIR = NUM_CH / 2;
  localparam int ADDR_W   = 4;

  localparam logic [ADDR_W-1:0] ADR_ENABLE = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_MODE   = 4'd9;

  typedef struct packed {
    logic                src_tmr;
    logic [NUM_PAIR-1:0] dither;
    logic [NUM_PAIR-1:0] fuse;
    logic [NUM_CH-1:0]   en;
  } pwm_ctrl_t;

endpackage

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel (
  input  logic src_tmr,
  input  logic tb_tick,
  input  logic tmr_ovf,
  output logic tick
);

  always_comb begin
    if (src_tmr) tick = tmr_ovf;
    else         tick = tb_tick;
  end

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_cascade_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [W-1:0]             wr_data,
  output logic [NUM_CH-1:0][W-1:0] per_sh,
  output logic [NUM_CH-1:0][W-1:0] dut_sh,
  output pwm_ctrl_t                ctrl
);

  localparam int IDX_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0][W-1:0] per_n, dut_n;
  pwm_ctrl_t                ctrl_n;
  logic [IDX_W-1:0]         idx;

  assign idx = wr_addr[IDX_W-1:0];

  always_comb begin
    per_n  = per_sh;
    dut_n  = dut_sh;
    ctrl_n = ctrl;
    if (wr_en) begin
      if (wr_addr < ADDR_W'(NUM_CH)) begin
        per_n[idx] = wr_data;
      end else if (wr_addr < ADDR_W'(2 * NUM_CH)) begin
        dut_n[idx] = wr_data;
      end else if (wr_addr == ADR_ENABLE) begin
        ctrl_n.en = wr_data[NUM_CH-1:0];
      end else if (wr_addr == ADR_MODE) begin
        ctrl_n.fuse    = wr_data[NUM_PAIR-1:0];
        ctrl_n.dither  = wr_data[2*NUM_PAIR-1:NUM_PAIR];
        ctrl_n.src_tmr = wr_data[2*NUM_PAIR];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh <= '0;
      dut_sh <= '0;
      ctrl   <= '0;
    end else begin
      per_sh <= per_n;
      dut_sh <= dut_n;
      ctrl   <= ctrl_n;
    end
  end

  AST_DUTY0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd4) |=> (dut_sh[0] == $past(wr_data))) // R7
    else $error("duty shadow 0 did not take the written value");

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_MODE) |=> (ctrl.src_tmr == $past(wr_data[2*NUM_PAIR]))) // R7
    else $error("mode write did not reach tick source bit");

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        en,
  input  logic              fuse,
  input  logic              dither,
  input  logic [1:0][W-1:0] per_sh,
  input  logic [1:0][W-1:0] dut_sh,
  output logic [1:0]        pwm
);

  localparam int DW = 2 * W;

  logic [1:0][W-1:0] cnt, cnt_n;
  logic [1:0][W-1:0] per_a, per_n;
  logic [1:0][W-1:0] dut_a, dut_n;

  logic [DW-1:0]     c16, p16, d16;
  logic [DW:0]       c16_inc;
  logic              wrap16;
  logic [1:0][W:0]   inc8;
  logic [1:0]        wrap8;
  logic [W-1:0]      sub_rev;
  logic              extra;
  logic [W:0]        thresh;

  assign c16     = {cnt[1], cnt[0]};
  assign p16     = {per_a[1], per_a[0]};
  assign d16     = {dut_a[1], dut_a[0]};
  assign c16_inc = {1'b0, c16} + 1'b1;

  always_comb begin
    if (dither) wrap16 = c16_inc[DW];
    else        wrap16 = (c16_inc >= {1'b0, p16});
  end

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      inc8[h]  = {1'b0, cnt[h]} + 1'b1;
      wrap8[h] = (inc8[h] >= {1'b0, per_a[h]});
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      sub_rev[i] = cnt[1][W-1-i];
    end
    extra  = (sub_rev < dut_a[0]);
    thresh = {1'b0, dut_a[1]} + {{W{1'b0}}, extra};
  end

  always_comb begin
    cnt_n = cnt;
    per_n = per_a;
    dut_n = dut_a;
    if (fuse) begin
      if (!en[0]) begin
        cnt_n = '0;
        per_n = per_sh;
        dut_n = dut_sh;
      end else if (tick) begin
        if (wrap16) begin
          cnt_n = '0;
          per_n = per_sh;
          dut_n = dut_sh;
        end else begin
          {cnt_n[1], cnt_n[0]} = c16_inc[DW-1:0];
        end
      end
    end else begin
      for (int h = 0; h < 2; h++) begin
        if (!en[h]) begin
          cnt_n[h] = '0;
          per_n[h] = per_sh[h];
          dut_n[h] = dut_sh[h];
        end else if (tick) begin
          if (wrap8[h]) begin
            cnt_n[h] = '0;
            per_n[h] = per_sh[h];
            dut_n[h] = dut_sh[h];
          end else begin
            cnt_n[h] = inc8[h][W-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    if (fuse) begin
      if (dither) pwm[0] = en[0] & ({1'b0, cnt[0]} < thresh);
      else        pwm[0] = en[0] & (c16 < d16);
      pwm[1] = 1'b0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        pwm[h] = en[h] & (cnt[h] < dut_a[h]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      per_a <= '0;
      dut_a <= '0;
    end else begin
      cnt   <= cnt_n;
      per_a <= per_n;
      dut_a <= dut_n;
    end
  end

  AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 2'b11 && !tick) |=> $stable(c16)) // R5
    else $error("counter moved without a selected tick");

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[0]) |=> (cnt[0] == '0)) // R4
    else $error("disabled counter not held at zero");

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en[0] && !tick) |=> $stable(dut_a[0])) // R6
    else $error("active duty changed outside a wrap");

  AST_CARRY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse && dither && en[0] && tick && (&cnt[0]) && !(&cnt[1]))
      |=> (cnt[0] == '0 && cnt[1] == $past(cnt[1]) + 1'b1)) // R8
    else $error("low byte carry did not advance high byte");

endmodule

// File: rtl/pwm_cascade.sv
module pwm_cascade
  import pwm_cascade_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_tick,
  input  logic              tmr_ovf,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [1:0]               rst_pipe;
  logic                     rst_int_n;
  logic                     tick;
  logic [NUM_CH-1:0][W-1:0] per_sh, dut_sh;
  pwm_ctrl_t                ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pwm_regfile #(.W(W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .per_sh  (per_sh),
    .dut_sh  (dut_sh),
    .ctrl    (ctrl)
  );

  pwm_tick_sel i_tick (
    .src_tmr (ctrl.src_tmr),
    .tb_tick (tb_tick),
    .tmr_ovf (tmr_ovf),
    .tick    (tick)
  );

  for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
    pwm_pair #(.W(W)) i_pair (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .tick   (tick),
      .en     (ctrl.en[2*g+1:2*g]),
      .fuse   (ctrl.fuse[g]),
      .dither (ctrl.dither[g]),
      .per_sh (per_sh[2*g+1:2*g]),
      .dut_sh (dut_sh[2*g+1:2*g]),
      .pwm    (pwm_out[2*g+1:2*g])
    );
  end

  AST_RESET_LOW: assert property (@(posedge clk)
    (!rst_int_n) |-> (pwm_out == '0)) // R1
    else $error("output high during reset");

endmodule

// File: tb/test_pwm_cascade.sv
module test_pwm_cascade;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tb_tick;
  logic       tmr_ovf;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] pwm_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  pwm_cascade i_pwm_cascade (
    .clk     (clk),
    .rst_n   (rst_n),
    .tb_tick (tb_tick),
    .tmr_ovf (tmr_ovf),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out)
  );

  // period, duty, expected high samples per period (R2, R3)
  localparam int NV = 10;
  localparam int VEC [NV][3] = '{
    '{10,   3,   3}, '{10,   0,   0}, '{10,  10,  10}, '{10, 200,  10},
    '{ 1,   0,   0}, '{ 1,   1,   1}, '{ 0,   5,   1}, '{255, 128, 128},
    '{ 7,   6,   6}, '{ 3,   1,   1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // caller stands at a negedge; returns at the next negedge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_hi(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_out[ch]);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int hi, hi2, hi3, mism;
    int s [40];
    rst_n = 1'b0; tb_tick = 1'b1; tmr_ovf = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    count_hi(0, 10, hi);
    chk("R1 outputs after reset", hi + int'(pwm_out), 0);
    wr(4'd8, 8'h01);
    count_hi(0, 5, hi);
    chk("R1 reset shadows zero", hi, 0);

    // vector table: 8-bit channel 0
    for (int v = 0; v < NV; v++) begin
      int win;
      win = (VEC[v][0] == 0) ? 1 : VEC[v][0];
      wr(4'd8, 8'h00);
      wr(4'd0, 8'(VEC[v][0]));
      wr(4'd4, 8'(VEC[v][1]));
      wr(4'd8, 8'h01);
      count_hi(0, 2 * win, hi);
      chk("R2 R3 period/duty vector", hi, 2 * VEC[v][2]);
    end

    // R4: disable holds low, re-enable starts at counter zero
    wr(4'd8, 8'h00);
    wr(4'd0, 8'd10);
    wr(4'd4, 8'd3);
    wr(4'd8, 8'h01);
    repeat (7) @(negedge clk);
    wr(4'd8, 8'h00);
    count_hi(0, 20, hi);
    chk("R4 disabled output low", hi, 0);
    wr(4'd8, 8'h01);
    mism = 0;
    for (int k = 0; k < 10; k++) begin
      if (int'(pwm_out[0]) != int'(k < 3)) mism++;
      @(negedge clk);
    end
    chk("R4 restart phase mismatches", mism, 0);

    // R5: timer overflow as tick source, time-base ignored
    wr(4'd8, 8'h00);
    wr(4'd9, 8'h10);
    wr(4'd8, 8'h01);
    count_hi(0, 20, hi);
    chk("R5 frozen without overflow", hi, 20);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      hi += int'(pwm_out[0]);
      tmr_ovf = (i % 4 == 3);
      @(negedge clk);
    end
    tmr_ovf = 1'b0;
    chk("R5 overflow-paced high count", hi, 12);
    wr(4'd9, 8'h00);

    // R6: mid-period write and write on the wrap edge
    wr(4'd8, 8'h00);
    wr(4'd4, 8'd3);
    wr(4'd8, 8'h01);
    for (int k = 0; k < 40; k++) begin
      s[k] = int'(pwm_out[0]);
      if (k == 4)       wr(4'd4, 8'd7);
      else if (k == 19) wr(4'd4, 8'd2);
      else              @(negedge clk);
    end
    for (int p = 0; p < 4; p++) begin
      int exp_p;
      hi = 0;
      for (int k = 0; k < 10; k++) hi += s[p*10+k];
      exp_p = (p == 0) ? 3 : (p == 3) ? 2 : 7;
      chk($sformatf("R6 period %0d high count", p), hi, exp_p);
    end

    // R10: independent channels
    wr(4'd8, 8'h00);
    wr(4'd0, 8'd4);  wr(4'd4, 8'd2);
    wr(4'd1, 8'd10); wr(4'd5, 8'd1);
    wr(4'd2, 8'd10); wr(4'd6, 8'd5);
    wr(4'd3, 8'd10); wr(4'd7, 8'd9);
    wr(4'd8, 8'h0F);
    begin
      int c [4];
      c = '{0, 0, 0, 0};
      for (int i = 0; i < 20; i++) begin
        for (int ch = 0; ch < 4; ch++) c[ch] += int'(pwm_out[ch]);
        @(negedge clk);
      end
      chk("R10 ch0", c[0], 10);
      chk("R10 ch1", c[1], 2);
      chk("R10 ch2", c[2], 10);
      chk("R10 ch3", c[3], 18);
    end

    // R8: both pairs fused, 16-bit periods
    wr(4'd8, 8'h00);
    wr(4'd9, 8'h03);
    wr(4'd0, 8'h05); wr(4'd1, 8'h01); wr(4'd4, 8'h00); wr(4'd5, 8'h01);
    wr(4'd2, 8'h00); wr(4'd3, 8'h02); wr(4'd6, 8'h80); wr(4'd7, 8'h01);
    wr(4'd8, 8'h05);
    hi = 0; hi2 = 0; hi3 = 0;
    for (int k = 0; k < 522; k++) begin
      hi += int'(pwm_out[0]);
      if (k < 512) hi2 += int'(pwm_out[2]);
      hi3 += int'(pwm_out[1]) + int'(pwm_out[3]);
      if (k == 255) chk("R8 carry sample 255", int'(pwm_out[0]), 1);
      if (k == 256) chk("R8 carry sample 256", int'(pwm_out[0]), 0);
      @(negedge clk);
    end
    chk("R8 pair A two periods", hi, 512);
    chk("R8 pair B one period", hi2, 384);
    chk("R8 odd pins low", hi3, 0);

    // R9: dithered pair A, period registers ignored
    wr(4'd8, 8'h00);
    wr(4'd9, 8'h05);
    wr(4'd0, 8'h05); wr(4'd1, 8'h00);
    wr(4'd4, 8'h03); wr(4'd5, 8'h02);
    wr(4'd8, 8'h01);
    hi = 0; hi2 = 0; hi3 = 0; mism = 0;
    for (int k = 0; k < 65536; k++) begin
      hi += int'(pwm_out[0]);
      if (k < 256) hi2 += int'(pwm_out[0]);
      else if (k < 512) hi3 += int'(pwm_out[0]);
      mism += int'(pwm_out[1]);
      @(negedge clk);
    end
    chk("R9 frame total", hi, 515);
    chk("R9 subperiod 0", hi2, 3);
    chk("R9 subperiod 1", hi3, 2);
    chk("R9 odd pin low", mism, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule